// File: doc/BRIEF.md
# Byte-Addressable Data Space Controller

This block connects a 16-bit processor load/store port to a word-wide data RAM built from two byte lanes. Each access carries a 16-bit byte address, a byte/word flag, a read or write strobe and write data. The controller decodes the address into one of four regions: a low register window, the implemented RAM, an unmapped gap, and a reserved upper half. It then steers the byte lanes and reports word accesses to odd addresses.

Register-window accesses go to an external register file through a forwarding port. That file reports through `regHit` whether a register exists at the address. RAM holds 2 KB at 0x0800–0x0FFF as two 1K×8 lane arrays. The two arrays share one word-address decode and have separate write enables. Read data comes out one cycle after the request. The address-error pulse comes out in the same cycle as the faulting request.

Top module: `dataSpaceCtrl`

## Requirements
- R1: A word written to an even address in 0x0800–0x0FFF is returned unchanged by a later word read of that address.
- R2: `rdValid` is high in exactly the cycle after a cycle with `rdEn` high, and `rdata` holds the result in that cycle.
- R3: A byte read returns the byte picked by address bit 0 on `rdata[7:0]` (0 = low byte, 1 = high byte), with `rdata[15:8]` zero.
- R4: A byte write stores `wdata[7:0]` into the lane picked by address bit 0 only, and leaves the other byte of that word unchanged.
- R5: `addrTrap` is high in the same cycle as a read or write that is a word access (`isByte`=0) to an odd address, and low in every other cycle.
- R6: A word read at an odd address still completes, with `rdValid` high, and returns the word at the address with bit 0 cleared.
- R7: A word write at an odd address modifies neither the RAM nor the register file, and raises no `regWrEn`.
- R8: An access below 0x0800 is forwarded. `regRdEn`/`regWrEn` are raised, `regAddr` carries the address, and `regByteEn` is 2'b01 for an even byte, 2'b10 for an odd byte and 2'b11 for a word. `regWdata` carries the write byte on both lanes for byte writes. A read returns `regRdata` when `regHit` is 1 and zero otherwise.
- R9: Reads of 0x1000–0x7FFF and of any address with bit 15 set return zero, and writes there change nothing.
- R10: After reset, with no strobe, `rdValid`, `rdata` and `addrTrap` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Byte effective address |
| isByte | input | 1 | 1 = byte access, 0 = word access |
| rdEn | input | 1 | Read request |
| wrEn | input | 1 | Write request |
| wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rdata | output | 16 | Read result, valid with rdValid |
| rdValid | output | 1 | Read result valid, one cycle after rdEn |
| addrTrap | output | 1 | Misaligned word access pulse |
| regRdEn | output | 1 | Register window read strobe |
| regWrEn | output | 1 | Register window write strobe |
| regByteEn | output | 2 | Register lane enables |
| regAddr | output | 16 | Register window byte address |
| regWdata | output | 16 | Lane-steered register write data |
| regRdata | input | 16 | Register file read word |
| regHit | input | 1 | A register exists at regAddr |

## Verification
Random traffic mixes byte and word reads and writes over all four regions at even and odd addresses. A byte-level shadow of the RAM and register file catches any write that lands in the wrong lane or in the wrong region. Directed sequences write a single byte and then read the whole word, which shows whether the neighbouring lane was disturbed. Odd word reads and writes followed by aligned reads separate the two misalignment outcomes: a read that completes and a write that is dropped. Register reads at implemented and unimplemented addresses separate data forwarding from zero fill.

// File: rtl/dscPkg.sv
package dscPkg;

  // Region classes decoded from the byte address.
  typedef enum logic [1:0] {
    RGN_REG   = 2'd0,
    RGN_RAM   = 2'd1,
    RGN_GAP   = 2'd2,
    RGN_UPPER = 2'd3
  } dscRegion_e;

  // Strobes handed from control to the datapath each cycle.
  typedef struct packed {
    logic       rdAny;   // a read is requested this cycle
    logic       ramRd;   // read the RAM lanes
    logic       regRd;   // read the register window
    logic [1:0] ramWe;   // per-lane RAM write enables
    logic [1:0] regWe;   // per-lane register write enables
    logic [1:0] lanes;   // lanes touched by the access
    logic       byteOp;  // byte-sized access
    logic       hiLane;  // byte address is odd
  } dscStrobe_t;

endpackage

// File: rtl/dscControl.sv
module dscControl
  import dscPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REG_BYTES = 2048,
  parameter int RAM_BASE  = 2048,
  parameter int RAM_BYTES = 2048,
  localparam int RAM_AW   = $clog2(RAM_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isByte,
  input  logic              rdEn,
  input  logic              wrEn,
  output dscStrobe_t        strb,
  output logic [RAM_AW-1:0] ramWordAddr,
  output logic              addrTrap
);

  localparam logic [ADDR_W:0] REG_END = (ADDR_W + 1)'(REG_BYTES);
  localparam logic [ADDR_W:0] RAM_LO  = (ADDR_W + 1)'(RAM_BASE);
  localparam logic [ADDR_W:0] RAM_HI  = (ADDR_W + 1)'(RAM_BASE + RAM_BYTES);

  dscRegion_e        region;
  logic [ADDR_W:0]   addrExt;
  logic [ADDR_W:0]   ramOff;
  logic              misaligned;
  logic              writeOk;
  logic [1:0]        laneMask;

  assign addrExt = {1'b0, addr};

  // Region decode: the upper half is checked first.
  always_comb begin
    if (addr[ADDR_W-1])
      region = RGN_UPPER;
    else if (addrExt < REG_END)
      region = RGN_REG;
    else if (addrExt >= RAM_LO && addrExt < RAM_HI)
      region = RGN_RAM;
    else
      region = RGN_GAP;
  end

  assign ramOff      = addrExt - RAM_LO;
  assign ramWordAddr = ramOff[RAM_AW:1];

  // Alignment and lane steering
  assign misaligned = !isByte && addr[0];
  assign writeOk    = wrEn && !misaligned;
  assign laneMask   = isByte ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;

  always_comb begin
    strb        = '0;
    strb.rdAny  = rdEn;
    strb.ramRd  = rdEn && (region == RGN_RAM);
    strb.regRd  = rdEn && (region == RGN_REG);
    strb.ramWe  = (writeOk && region == RGN_RAM) ? laneMask : 2'b00;
    strb.regWe  = (writeOk && region == RGN_REG) ? laneMask : 2'b00;
    strb.lanes  = laneMask;
    strb.byteOp = isByte;
    strb.hiLane = addr[0];
  end

  assign addrTrap = (rdEn || wrEn) && misaligned;

  // R7
  drop_misaligned_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isByte && addr[0]) |-> (strb.ramWe == 2'b00 && strb.regWe == 2'b00));

  // R4
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    isByte |-> ($countones(strb.ramWe) <= 1 && $countones(strb.regWe) <= 1));

  // R9
  one_read_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ramRd, strb.regRd}));

  // R5
  trap_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrTrap |-> (rdEn || wrEn));

endmodule

// File: rtl/dscDatapath.sv
module dscDatapath
  import dscPkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int DATA_W    = 16,
  localparam int LANES    = DATA_W / 8,
  localparam int RAM_WORDS = RAM_BYTES / 2,
  localparam int RAM_AW   = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dscStrobe_t        strb,
  input  logic [RAM_AW-1:0] ramWordAddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regHit,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid
);

  logic [DATA_W-1:0] laneWdata;
  logic [DATA_W-1:0] ramWord;
  logic [DATA_W-1:0] regHold;
  logic [DATA_W-1:0] srcWord;
  logic              srcRam;
  logic              srcReg;
  logic              byteQ;
  logic              hiQ;

  // Byte writes carry their byte on both lanes; the enables pick the lane.
  assign laneWdata = strb.byteOp ? {wdata[7:0], wdata[7:0]} : wdata;
  assign regWdata  = laneWdata;

  // Lane arrays: shared word address, separate write enable per lane.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] mem [RAM_WORDS];
    logic [7:0] rdByte;

    always_ff @(posedge clk) begin
      if (strb.ramWe[g])
        mem[ramWordAddr] <= laneWdata[g*8 +: 8];
      if (strb.ramRd)
        rdByte <= mem[ramWordAddr];
    end

    assign ramWord[g*8 +: 8] = rdByte;
  end

  // Read stage: remember the source and the byte selection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      srcRam  <= 1'b0;
      srcReg  <= 1'b0;
      byteQ   <= 1'b0;
      hiQ     <= 1'b0;
      regHold <= '0;
    end else begin
      rdValid <= strb.rdAny;
      srcRam  <= strb.ramRd;
      srcReg  <= strb.regRd;
      byteQ   <= strb.byteOp;
      hiQ     <= strb.hiLane;
      if (strb.regRd)
        regHold <= regHit ? regRdata : '0;
    end
  end

  always_comb begin
    if (srcRam)
      srcWord = ramWord;
    else if (srcReg)
      srcWord = regHold;
    else
      srcWord = '0;
  end

  always_comb begin
    if (!rdValid)
      rdata = '0;
    else if (byteQ)
      rdata = {{(DATA_W - 8){1'b0}}, hiQ ? srcWord[15:8] : srcWord[7:0]};
    else
      rdata = srcWord;
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdAny |=> rdValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdAny |=> !rdValid);

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && byteQ) |-> (rdata[15:8] == 8'h00));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !srcRam && !srcReg) |-> (rdata == '0));

endmodule

// File: rtl/dataSpaceCtrl.sv
module dataSpaceCtrl
  import dscPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int REG_BYTES = 2048,
  parameter int RAM_BASE  = 2048,
  parameter int RAM_BYTES = 2048,
  localparam int RAM_AW   = $clog2(RAM_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isByte,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid,
  output logic              addrTrap,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [1:0]        regByteEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regHit
);

  dscStrobe_t        strb;
  logic [RAM_AW-1:0] ramWordAddr;

  dscControl #(
    .ADDR_W    (ADDR_W),
    .REG_BYTES (REG_BYTES),
    .RAM_BASE  (RAM_BASE),
    .RAM_BYTES (RAM_BYTES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .isByte      (isByte),
    .rdEn        (rdEn),
    .wrEn        (wrEn),
    .strb        (strb),
    .ramWordAddr (ramWordAddr),
    .addrTrap    (addrTrap)
  );

  dscDatapath #(
    .RAM_BYTES (RAM_BYTES),
    .DATA_W    (DATA_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ramWordAddr (ramWordAddr),
    .wdata       (wdata),
    .regRdata    (regRdata),
    .regHit      (regHit),
    .regWdata    (regWdata),
    .rdata       (rdata),
    .rdValid     (rdValid)
  );

  assign regRdEn   = strb.regRd;
  assign regWrEn   = |strb.regWe;
  assign regByteEn = strb.lanes;
  assign regAddr   = addr;

endmodule

// File: tb/test_dataSpaceCtrl.sv
`timescale 1ns/1ps
module test_dataSpaceCtrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] addr;
  logic        isByte, rdEn, wrEn;
  logic [15:0] wdata, rdata;
  logic        rdValid, addrTrap;
  logic        regRdEn, regWrEn;
  logic [1:0]  regByteEn;
  logic [15:0] regAddr, regWdata, regRdata;
  logic        regHit;

  always #4 clk = ~clk;

  dataSpaceCtrl i_dataSpaceCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .isByte(isByte), .rdEn(rdEn),
    .wrEn(wrEn), .wdata(wdata), .rdata(rdata), .rdValid(rdValid),
    .addrTrap(addrTrap), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regByteEn(regByteEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .regHit(regHit)
  );

  // External register file: 16 words at 0x0000-0x001F.
  logic [15:0] regMem [16];
  assign regHit   = regAddr < 16'h0020;
  assign regRdata = regMem[regAddr[4:1]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regMem[i] <= 16'(i) * 16'h1111;
    end else if (regWrEn && regHit) begin
      if (regByteEn[0]) regMem[regAddr[4:1]][7:0]  <= regWdata[7:0];
      if (regByteEn[1]) regMem[regAddr[4:1]][15:8] <= regWdata[15:8];
    end
  end

  // Bench shadow models
  logic [7:0]  ramModel [2048];
  logic [15:0] regModel [16];
  int nRun = 0;
  int nFail = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp,
                     input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [15:0] a, input bit byteOp);
    logic [15:0] al, w;
    al = {a[15:1], 1'b0};
    if (a[15])                 w = 16'h0;
    else if (a < 16'h0020)     w = regModel[a[4:1]];
    else if (a < 16'h0800)     w = 16'h0;
    else if (a < 16'h1000)     w = {ramModel[al - 16'h0800 + 1], ramModel[al - 16'h0800]};
    else                       w = 16'h0;
    if (byteOp) return {8'h00, a[0] ? w[15:8] : w[7:0]};
    return w;
  endfunction

  task automatic doAccess(input logic [15:0] a, input bit byteOp, input bit rd,
                          input bit wr, input logic [15:0] wd, input string tag);
    logic [15:0] e;
    bit misal, inReg;
    logic [15:0] off;
    misal = !byteOp && a[0];
    inReg = !a[15] && a < 16'h0800;
    e = expRead(a, byteOp);
    addr = a; isByte = byteOp; rdEn = rd; wrEn = wr; wdata = wd;
    #1;
    chk("R5", {15'h0, addrTrap}, {15'h0, (rd || wr) && misal}, "addrTrap");
    chk("R8", {15'h0, regRdEn}, {15'h0, rd && inReg}, "regRdEn");
    chk("R7", {15'h0, regWrEn}, {15'h0, wr && inReg && !misal}, "regWrEn");
    if ((rd || wr) && inReg) begin
      chk("R8", {14'h0, regByteEn}, {14'h0, byteOp ? (a[0] ? 2'b10 : 2'b01) : 2'b11},
          "regByteEn");
      chk("R8", regAddr, a, "regAddr");
    end
    if (wr && inReg && !misal)
      chk("R8", regWdata, byteOp ? {wd[7:0], wd[7:0]} : wd, "regWdata");
    @(posedge clk);
    if (wr && !misal) begin
      if (!a[15] && a >= 16'h0800 && a < 16'h1000) begin
        off = a - 16'h0800;
        if (byteOp) ramModel[off] = wd[7:0];
        else begin ramModel[off] = wd[7:0]; ramModel[off + 1] = wd[15:8]; end
      end else if (a < 16'h0020) begin
        if (byteOp) begin
          if (a[0]) regModel[a[4:1]][15:8] = wd[7:0];
          else      regModel[a[4:1]][7:0]  = wd[7:0];
        end else regModel[a[4:1]] = wd;
      end
    end
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    chk("R2", {15'h0, rdValid}, {15'h0, rd}, "rdValid");
    if (rd) chk(tag, rdata, e, "rdata");
  endtask

  // Watchdog
  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) regModel[i] = 16'(i) * 16'h1111;
    rstN = 1'b0; addr = '0; isByte = 1'b0; rdEn = 1'b0; wrEn = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {15'h0, rdValid}, 16'h0, "rdValid in reset");
    chk("R10", rdata, 16'h0, "rdata in reset");
    chk("R10", {15'h0, addrTrap}, 16'h0, "addrTrap idle");
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", {15'h0, rdValid}, 16'h0, "rdValid after reset");

    // R1: fill all RAM words
    for (int i = 0; i < 1024; i++)
      doAccess(16'h0800 + 16'(2 * i), 0, 0, 1, 16'(i) * 16'h9E37 ^ 16'h5A5A, "R1");
    doAccess(16'h0800, 0, 1, 0, 16'h0, "R1");
    doAccess(16'h0FFE, 0, 1, 0, 16'h0, "R1");

    // R3: byte reads of both lanes
    doAccess(16'h0A10, 1, 1, 0, 16'h0, "R3");
    doAccess(16'h0A11, 1, 1, 0, 16'h0, "R3");

    // R4: byte writes leave the other lane alone
    doAccess(16'h0805, 1, 0, 1, 16'hCDAB, "R4");
    doAccess(16'h0804, 0, 1, 0, 16'h0, "R4");
    doAccess(16'h0806, 1, 0, 1, 16'h1277, "R4");
    doAccess(16'h0806, 0, 1, 0, 16'h0, "R4");

    // R6: misaligned word read completes with the aligned word
    doAccess(16'h0807, 0, 1, 0, 16'h0, "R6");
    doAccess(16'h0013, 0, 1, 0, 16'h0, "R6");

    // R7: misaligned word write is dropped
    doAccess(16'h0809, 0, 0, 1, 16'hFFFF, "R7");
    doAccess(16'h0808, 0, 1, 0, 16'h0, "R7");
    doAccess(16'h0005, 0, 0, 1, 16'hBEEF, "R7");
    doAccess(16'h0004, 0, 1, 0, 16'h0, "R7");

    // R8: register window hit, miss, byte write
    doAccess(16'h0006, 0, 0, 1, 16'h1234, "R8");
    doAccess(16'h0006, 0, 1, 0, 16'h0, "R8");
    doAccess(16'h0003, 1, 0, 1, 16'h00C3, "R8");
    doAccess(16'h0002, 0, 1, 0, 16'h0, "R8");
    doAccess(16'h0100, 0, 1, 0, 16'h0, "R8");

    // R9: gap and upper half
    doAccess(16'h1808, 0, 0, 1, 16'hA5A5, "R9");
    doAccess(16'h1808, 0, 1, 0, 16'h0, "R9");
    doAccess(16'h0808, 0, 1, 0, 16'h0, "R9");
    doAccess(16'h8808, 0, 0, 1, 16'h5A5A, "R9");
    doAccess(16'h8808, 0, 1, 0, 16'h0, "R9");
    doAccess(16'hFFFF, 1, 1, 0, 16'h0, "R9");
    doAccess(16'h0808, 0, 1, 0, 16'h0, "R9");

    // Random mixed traffic over all regions (R1)
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      int sel;
      bit rd;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       a = 16'h0800 + 16'($urandom_range(0, 2047));
      else if (sel < 7)  a = 16'($urandom_range(0, 16'h1F));
      else if (sel < 8)  a = 16'($urandom_range(16'h20, 16'h7FF));
      else if (sel < 9)  a = 16'($urandom_range(16'h1000, 16'h7FFF));
      else               a = 16'($urandom_range(16'h8000, 16'hFFFF));
      rd = $urandom_range(0, 1) == 1;
      doAccess(a, $urandom_range(0, 1) == 1, rd, !rd, 16'($urandom()), "R1");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule